// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates, one per clock, the column addresses that a synchronous DRAM read or write burst walks through. A command edge (`start_i`) supplies the first column, a 3-bit length code and an ordering bit. On the next clock the block puts the first column on its output. It keeps stepping until the programmed number of beats has been issued. A flag marks the final beat of every finite burst.

Two orderings are supported. Sequential ordering counts the low column bits upward and wraps inside the aligned block whose size is the burst length. Interleaved ordering XORs the starting column with a beat index. With sequential ordering a whole-row mode is also available: it walks the full column space and wraps, and only a terminate or a new command ends it. A new command restarts the sequence on any cycle. A terminate ends it on the next clock. While the clock enable is low the whole block is frozen.

Top module: `sdram_col_burst`

## Requirements
- R1: After a synchronous active-low reset, `col_valid_o`, `col_last_o` and `len_err_o` are 0 and `col_addr_o` is 0.
- R2: When `clk_en_i` and `start_i` are high at a clock edge, the outputs after that edge show `col_valid_o`=1 and `col_addr_o` equal to the sampled `start_col_i`.
- R3: With `burst_type_i`=0 (sequential) and length code 000/001/010/011 (lengths 1/2/4/8), beat k has address (start with its low log2(L) bits cleared) + ((start + k) mod L).
- R4: With `burst_type_i`=1 (interleaved) and length code 000–011, beat k has address start XOR k, for k from 0 to L−1.
- R5: A burst of length 1 raises `col_last_o` together with its only beat, and `col_valid_o` is 0 after the next edge.
- R6: `col_last_o` is high on the final beat of a finite burst only, and `col_valid_o` falls on the edge after that beat.
- R7: Code 111 with sequential ordering gives a whole-row burst. The address is (start + k) mod 2^COL_W, `col_last_o` never rises, and the burst runs until stopped.
- R8: `term_i` at an enabled edge clears `col_valid_o` after that edge. If `start_i` is also high at that edge, the new burst starts instead.
- R9: `start_i` during a running burst discards it, and the next beat is the first beat of the new sequence.
- R10: Codes 100, 101 and 110, and code 111 with interleaved ordering, are reserved. They produce a one-beat burst with `len_err_o`=1. `len_err_o` holds until the next accepted start, which recomputes it.
- R11: While `clk_en_i` is 0, all outputs hold their values, and `start_i` and `term_i` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| clk_en_i | input | 1 | Clock enable; low freezes all state |
| start_i | input | 1 | Read or write command: start a new burst |
| start_col_i | input | COL_W | First column of the burst |
| len_code_i | input | 3 | Burst length code |
| burst_type_i | input | 1 | 0 sequential, 1 interleaved |
| term_i | input | 1 | Burst terminate |
| col_addr_o | output | COL_W | Current column address |
| col_valid_o | output | 1 | A beat is being issued |
| col_last_o | output | 1 | Current beat is the final one |
| len_err_o | output | 1 | Last accepted start used a reserved code |

## Verification
The bench builds the block with its default COL_W of 9, so a whole-row burst covers 512 columns. A start near the top of the row makes the wrap from 511 back to 0 show up within a few beats. The starting columns are chosen with non-zero offsets inside their aligned blocks, so each ordering's wrap and XOR pattern is checked on every beat. The interruption cases are also covered: terminate, restart, both at once, and a held clock enable.

// File: rtl/sdram_col_burst_pkg.sv
// Package: shared encodings for the burst column sequencer.
// Assumes length codes are 3 bits; codes map to lengths 1,2,4,8 and whole-row.
package sdram_col_burst_pkg;
    localparam int LEN_CODE_W = 3;
    localparam int OFS_W      = 3;   // width of in-block offset for length 8

    typedef enum logic {
        ORD_SEQ = 1'b0,
        ORD_INT = 1'b1
    } order_e;

    typedef enum logic [LEN_CODE_W-1:0] {
        LC_1    = 3'b000,
        LC_2    = 3'b001,
        LC_4    = 3'b010,
        LC_8    = 3'b011,
        LC_ROW  = 3'b111
    } len_code_e;
endpackage

// File: rtl/sdram_len_decode.sv
// Module: decodes the length code and ordering into a beat mask.
// Produces mask = length-1, a whole-row flag and a reserved-code flag.
// Assumes reserved codes collapse to a single-beat burst.
module sdram_len_decode
    import sdram_col_burst_pkg::*;
(
    input  logic [LEN_CODE_W-1:0] code_i,
    input  logic                  order_i,
    output logic [OFS_W-1:0]      mask_o,
    output logic                  row_o,
    output logic                  err_o
);
    // Map each code to its mask; flag reserved combinations.
    always_comb begin
        mask_o = '0;
        row_o  = 1'b0;
        err_o  = 1'b0;
        case (code_i)
            LC_1:   mask_o = 3'd0;
            LC_2:   mask_o = 3'd1;
            LC_4:   mask_o = 3'd3;
            LC_8:   mask_o = 3'd7;
            LC_ROW: begin
                if (order_i == ORD_SEQ) row_o = 1'b1;
                else                    err_o = 1'b1;
            end
            default: err_o = 1'b1;
        endcase
    end
endmodule

// File: rtl/sdram_col_order.sv
// Module: combinational column address for a given beat index.
// Whole-row: base+beat modulo 2^COL_W. Sequential: low bits wrap in the
// aligned block. Interleaved: base XOR beat. Assumes COL_W > OFS_W.
module sdram_col_order
    import sdram_col_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic [COL_W-1:0] base_i,
    input  logic [COL_W-1:0] beat_i,
    input  logic [OFS_W-1:0] mask_i,
    input  logic             row_i,
    input  logic             order_i,
    output logic [COL_W-1:0] addr_o
);
    localparam int PAD_W = COL_W - OFS_W;

    logic [COL_W-1:0] mask_ext;
    logic [COL_W-1:0] sum;

    // Widen the mask to the column width.
    always_comb mask_ext = {{PAD_W{1'b0}}, mask_i};

    // Running sum used by both incrementing orders.
    always_comb sum = base_i + beat_i;

    // Pick the address form for the active ordering.
    always_comb begin
        if (row_i)
            addr_o = sum;
        else if (order_i == ORD_INT)
            addr_o = base_i ^ (beat_i & mask_ext);
        else
            addr_o = (base_i & ~mask_ext) | (sum & mask_ext);
    end
endmodule

// File: rtl/sdram_col_burst.sv
// Module: burst column address sequencer (top).
// Registers the command, then steps a beat counter each enabled clock,
// reporting the column, a valid flag and a final-beat flag.
// Assumes start has priority over terminate; clk_en_i low freezes everything.
module sdram_col_burst
    import sdram_col_burst_pkg::*;
#(
    parameter int COL_W = 9
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clk_en_i,
    input  logic                  start_i,
    input  logic [COL_W-1:0]      start_col_i,
    input  logic [LEN_CODE_W-1:0] len_code_i,
    input  logic                  burst_type_i,
    input  logic                  term_i,
    output logic [COL_W-1:0]      col_addr_o,
    output logic                  col_valid_o,
    output logic                  col_last_o,
    output logic                  len_err_o
);
    localparam int PAD_W = COL_W - OFS_W;

    logic [OFS_W-1:0] dec_mask;
    logic             dec_row;
    logic             dec_err;

    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat_q;
    logic [OFS_W-1:0] mask_q;
    logic             row_q;
    logic             order_q;
    logic             valid_q;
    logic             err_q;
    logic             final_beat;

    sdram_len_decode u_dec (
        .code_i  (len_code_i),
        .order_i (burst_type_i),
        .mask_o  (dec_mask),
        .row_o   (dec_row),
        .err_o   (dec_err)
    );

    sdram_col_order #(.COL_W(COL_W)) u_ord (
        .base_i  (base_q),
        .beat_i  (beat_q),
        .mask_i  (mask_q),
        .row_i   (row_q),
        .order_i (order_q),
        .addr_o  (col_addr_o)
    );

    // Final beat of a finite burst: beat index reached length-1.
    always_comb final_beat = !row_q && (beat_q == {{PAD_W{1'b0}}, mask_q});

    // Burst state: load on start, stop on terminate or last beat, else step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            beat_q  <= '0;
            mask_q  <= '0;
            row_q   <= 1'b0;
            order_q <= 1'b0;
            valid_q <= 1'b0;
            err_q   <= 1'b0;
        end else if (clk_en_i) begin
            if (start_i) begin
                base_q  <= start_col_i;
                beat_q  <= '0;
                mask_q  <= dec_mask;
                row_q   <= dec_row;
                order_q <= burst_type_i;
                valid_q <= 1'b1;
                err_q   <= dec_err;
            end else if (term_i) begin
                valid_q <= 1'b0;
            end else if (valid_q) begin
                if (final_beat) valid_q <= 1'b0;
                else            beat_q  <= beat_q + 1'b1;
            end
        end
    end

    assign col_valid_o = valid_q;
    assign col_last_o  = valid_q && final_beat;
    assign len_err_o   = err_q;

    // R2
    start_loads_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_i && start_i) |=> (col_valid_o && col_addr_o == $past(start_col_i)));

    // R8
    term_stops_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_i && term_i && !start_i) |=> !col_valid_o);

    // R6
    last_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_en_i && col_last_o && !start_i) |=> !col_valid_o);

    // R11
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clk_en_i && $past(rst_n)) |=> ($stable(col_addr_o) && $stable(col_valid_o)
                                         && $stable(col_last_o) && $stable(len_err_o)));

    // R10
    reserved_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (col_valid_o && len_err_o) |-> col_last_o);
endmodule

// File: tb/sdram_col_burst_tb_top.sv
// Directed bench for the burst column address sequencer.
module sdram_col_burst_tb_top;
    localparam int COL_W = 9;
    localparam int ROW   = 1 << COL_W;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             clk_en_i = 1'b1;
    logic             start_i = 1'b0;
    logic [COL_W-1:0] start_col_i = '0;
    logic [2:0]       len_code_i = '0;
    logic             burst_type_i = 1'b0;
    logic             term_i = 1'b0;
    logic [COL_W-1:0] col_addr_o;
    logic             col_valid_o;
    logic             col_last_o;
    logic             len_err_o;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sdram_col_burst #(.COL_W(COL_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .clk_en_i(clk_en_i), .start_i(start_i),
        .start_col_i(start_col_i), .len_code_i(len_code_i),
        .burst_type_i(burst_type_i), .term_i(term_i), .col_addr_o(col_addr_o),
        .col_valid_o(col_valid_o), .col_last_o(col_last_o), .len_err_o(len_err_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int exp_col(input int s, input int code, input int ty, input int k);
        int len;
        if (code == 7 && ty == 0) return (s + k) % ROW;
        len = (code <= 3) ? (1 << code) : 1;
        if (ty == 1) return s ^ k;
        return (s / len) * len + ((s % len + k) % len);
    endfunction

    // Drive a command at a negedge; returns at the negedge showing beat 0.
    task automatic issue(input int s, input int code, input int ty);
        start_i = 1'b1; start_col_i = COL_W'(s); len_code_i = 3'(code);
        burst_type_i = ty[0];
        @(negedge clk);
        start_i = 1'b0;
    endtask

    // Check n beats of a finite burst, then that valid has dropped.
    task automatic walk(input string tag, input int s, input int code, input int ty, input int n);
        for (int k = 0; k < n; k++) begin
            chk({tag, " addr"}, col_addr_o, exp_col(s, code, ty, k));
            chk({tag, " valid"}, col_valid_o, 1);
            chk({tag, " last"}, col_last_o, (k == n - 1) ? 1 : 0);
            @(negedge clk);
        end
        chk({tag, " end valid"}, col_valid_o, 0);
    endtask

    task automatic t_reset();
        chk("R1 valid", col_valid_o, 0);
        chk("R1 last", col_last_o, 0);
        chk("R1 err", len_err_o, 0);
        chk("R1 addr", col_addr_o, 0);
    endtask

    task automatic t_seq();
        issue(13, 2, 0);  walk("R3 seq4", 13, 2, 0, 4);
        issue(506, 3, 0); walk("R3 seq8", 506, 3, 0, 8);
        issue(7, 1, 0);   walk("R3 seq2", 7, 1, 0, 2);
        chk("R2 err clear", len_err_o, 0);
    endtask

    task automatic t_int();
        issue(13, 2, 1);  walk("R4 int4", 13, 2, 1, 4);
        issue(261, 3, 1); walk("R4 int8", 261, 3, 1, 8);
    endtask

    task automatic t_len1();
        issue(55, 0, 0);  walk("R5 len1", 55, 0, 0, 1);
        issue(300, 3, 0); walk("R6 last8", 300, 3, 0, 8);
    endtask

    task automatic t_row();
        issue(500, 7, 0);
        for (int k = 0; k < 20; k++) begin
            chk("R7 row addr", col_addr_o, (500 + k) % ROW);
            chk("R7 row nolast", col_last_o, 0);
            @(negedge clk);
        end
        chk("R7 still valid", col_valid_o, 1);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk("R8 term", col_valid_o, 0);
        @(negedge clk);
        chk("R8 stays idle", col_valid_o, 0);
    endtask

    task automatic t_term_start();
        issue(8, 2, 0);
        term_i = 1'b1;
        issue(20, 1, 0);
        term_i = 1'b0;
        walk("R8 start wins", 20, 1, 0, 2);
    endtask

    task automatic t_interrupt();
        issue(0, 3, 0);
        @(negedge clk); @(negedge clk);
        chk("R9 before", col_addr_o, 2);
        issue(100, 2, 1);
        walk("R9 restart", 100, 2, 1, 4);
    endtask

    task automatic t_reserved();
        issue(77, 5, 0);
        chk("R10 err", len_err_o, 1);
        walk("R10 code5", 77, 5, 0, 1);
        chk("R10 err held", len_err_o, 1);
        issue(90, 7, 1);
        chk("R10 int row err", len_err_o, 1);
        walk("R10 code7int", 90, 7, 1, 1);
        issue(90, 4, 0);  walk("R10 code4", 90, 4, 0, 1);
        issue(91, 6, 1);  walk("R10 code6", 91, 6, 1, 1);
        issue(16, 1, 0);
        chk("R10 err cleared", len_err_o, 0);
        walk("R10 good", 16, 1, 0, 2);
    endtask

    task automatic t_clken();
        issue(40, 3, 0);
        chk("R11 b0", col_addr_o, 40);
        @(negedge clk);
        chk("R11 b1", col_addr_o, 41);
        clk_en_i = 1'b0; term_i = 1'b1; start_i = 1'b1; start_col_i = 9'd200;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            chk("R11 hold addr", col_addr_o, 41);
            chk("R11 hold valid", col_valid_o, 1);
        end
        clk_en_i = 1'b1; term_i = 1'b0; start_i = 1'b0;
        @(negedge clk);
        chk("R11 resume", col_addr_o, 42);
        term_i = 1'b1;
        @(negedge clk);
        term_i = 1'b0;
        chk("R8 term mid", col_valid_o, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_seq();
        t_int();
        t_len1();
        t_row();
        t_term_start();
        t_interrupt();
        t_reserved();
        t_clken();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule